// File: doc/BRIEF.md
# Single-Bit Logic Unit with Carry Accumulator

This block carries out one-bit operations on the bit space of a small 8-bit controller. A single register, the carry, acts as a one-bit accumulator. An operation is started by pulsing `start` with an operation code and an 8-bit bit address. The block turns the bit address into a byte address and a bit index. It reads that byte from the internal RAM / special-register space, changes at most one bit, and writes the byte back when the operation needs a write. It also updates the carry and reports whether a bit-conditional jump would be taken.

Every operation takes the same fixed sequence: one read cycle, then one commit cycle. This holds even when the operation only touches the carry. The caller therefore sees a uniform latency. Bit addresses below 80H fall in a sixteen-byte RAM window at bytes 20H to 2FH. Addresses from 80H upwards select one bit of a special register whose address is a multiple of eight. Special registers at other addresses cannot be reached this way.

Top module: `bit_boolean_unit`

## Requirements
- R1: A bit address below 80H selects RAM byte 20H + addr[6:3], bit addr[2:0]. For example, 05H selects bit 5 of 20H and 7FH selects bit 7 of 2FH.
- R2: A bit address of 80H or more selects the special register at {addr[7:3],000}, bit addr[2:0]. For example, 93H selects bit 3 of 90H.
- R3: Set (op 0), clear (op 1) and complement (op 2) write back the read byte with only the addressed bit forced to 1, forced to 0 or inverted. The carry stays unchanged.
- R4: Carry set (op 3), carry clear (op 4) and carry complement (op 5) change only the carry and issue no write.
- R5: Op 6 gives C = C AND bit, op 7 gives C = C AND NOT bit, op 8 gives C = C OR bit, and op 9 gives C = C OR NOT bit. None of these writes memory.
- R6: Op 10 copies the addressed bit into C without a write. Op 11 writes C into the addressed bit and keeps the other seven bits.
- R7: The jump result is the bit for op 12, the inverted bit for op 13, and the bit for op 14. Op 14 also writes the bit back to 0, but only when the bit was 1.
- R8: A `start` seen while idle makes `busy` high for exactly two cycles. `done` is high in the second of these cycles. Writes and jump results appear only while `done` is high, and the new carry is visible in the cycle after `done`. A `start` while busy is ignored.
- R9: After reset, carry, `busy`, `done`, `jump_take` and `mem_wr_en` are all 0.
- R10: Op 15 is a no-operation: no write, no jump, and the carry is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken only while idle) |
| op | input | 4 | Operation code, see requirements |
| bit_addr | input | 8 | Bit address |
| mem_rd_addr | output | 8 | Byte address to read |
| mem_rd_data | input | 8 | Byte read back (combinational) |
| mem_wr_en | output | 1 | Byte write strobe |
| mem_wr_addr | output | 8 | Byte address to write |
| mem_wr_data | output | 8 | Byte to write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Commit cycle of an operation |
| jump_take | output | 1 | Bit test passed (valid with done) |
| carry | output | 1 | Carry flag |

## Verification
The bench targets the edges of the address map: 7FH against 80H, the last RAM byte, and the top special register at F8H. A wrong decode would hit a neighbouring byte or a misaligned register. The read-modify-write ops are run on bytes holding mixed bit patterns, so a mask error that clobbers neighbouring bits shows up in the written byte. The set-then-clear test is run on both a set bit and a clear bit, because a design that always writes would show a spurious strobe on the clear case. A second start is raised while the block is busy: a design that accepted it would produce an extra done and would change a bit that a later test reads back.

// File: rtl/bitu_pkg.sv
package bitu_pkg;
  typedef enum logic [3:0] {
    OP_BSET   = 4'd0,
    OP_BCLR   = 4'd1,
    OP_BINV   = 4'd2,
    OP_CSET   = 4'd3,
    OP_CCLR   = 4'd4,
    OP_CINV   = 4'd5,
    OP_CAND   = 4'd6,
    OP_CANDN  = 4'd7,
    OP_COR    = 4'd8,
    OP_CORN   = 4'd9,
    OP_LDC    = 4'd10,
    OP_STC    = 4'd11,
    OP_TSET   = 4'd12,
    OP_TCLR   = 4'd13,
    OP_TSETCL = 4'd14,
    OP_NONE   = 4'd15
  } bitu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } bitu_st_e;
endpackage

// File: rtl/bitu_addr_map.sv
module bitu_addr_map #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int RAM_BASE = 32
) (
  input  logic [ADDR_W-1:0]         bit_addr,
  output logic [ADDR_W-1:0]         byte_addr,
  output logic [$clog2(DATA_W)-1:0] bit_idx
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int ROW_W = ADDR_W - 1 - IDX_W;

  function automatic logic [ADDR_W-1:0] to_byte(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] row;
    row = {{(ADDR_W-ROW_W){1'b0}}, a[ADDR_W-2:IDX_W]};
    if (a[ADDR_W-1]) to_byte = {a[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
    else             to_byte = ADDR_W'(RAM_BASE) + row;
  endfunction

  assign byte_addr = to_byte(bit_addr);
  assign bit_idx   = bit_addr[IDX_W-1:0];
endmodule

// File: rtl/bitu_alu.sv
module bitu_alu
  import bitu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  bitu_op_e                  op,
  input  logic [DATA_W-1:0]         byte_in,
  input  logic [$clog2(DATA_W)-1:0] bit_idx,
  input  logic                      carry_in,
  output logic                      wr_need,
  output logic [DATA_W-1:0]         byte_out,
  output logic                      carry_out,
  output logic                      test_hit
);
  function automatic logic [DATA_W-1:0] put_bit(input logic [DATA_W-1:0] b,
      input logic [$clog2(DATA_W)-1:0] i, input logic v);
    logic [DATA_W-1:0] r;
    r    = b;
    r[i] = v;
    return r;
  endfunction

  logic sel;
  assign sel = byte_in[bit_idx];

  always_comb begin
    wr_need   = 1'b0;
    byte_out  = byte_in;
    carry_out = carry_in;
    test_hit  = 1'b0;
    unique case (op)
      OP_BSET:   begin wr_need = 1'b1; byte_out = put_bit(byte_in, bit_idx, 1'b1); end
      OP_BCLR:   begin wr_need = 1'b1; byte_out = put_bit(byte_in, bit_idx, 1'b0); end
      OP_BINV:   begin wr_need = 1'b1; byte_out = put_bit(byte_in, bit_idx, ~sel); end
      OP_CSET:   carry_out = 1'b1;
      OP_CCLR:   carry_out = 1'b0;
      OP_CINV:   carry_out = ~carry_in;
      OP_CAND:   carry_out = carry_in & sel;
      OP_CANDN:  carry_out = carry_in & ~sel;
      OP_COR:    carry_out = carry_in | sel;
      OP_CORN:   carry_out = carry_in | ~sel;
      OP_LDC:    carry_out = sel;
      OP_STC:    begin wr_need = 1'b1; byte_out = put_bit(byte_in, bit_idx, carry_in); end
      OP_TSET:   test_hit = sel;
      OP_TCLR:   test_hit = ~sel;
      OP_TSETCL: begin
        test_hit = sel;
        wr_need  = sel;
        byte_out = put_bit(byte_in, bit_idx, 1'b0);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bit_boolean_unit.sv
module bit_boolean_unit
  import bitu_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int RAM_BASE = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        op,
  input  logic [ADDR_W-1:0] bit_addr,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              busy,
  output logic              done,
  output logic              jump_take,
  output logic              carry
);
  localparam int IDX_W = $clog2(DATA_W);

  bitu_st_e          st_q;
  bitu_op_e          op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] byte_q;
  logic              carry_q;

  logic [ADDR_W-1:0] byte_addr;
  logic [IDX_W-1:0]  bit_idx;
  logic              alu_wr, alu_carry, alu_hit;
  logic [DATA_W-1:0] alu_byte;

  // named events for the checker
  logic evt_accept, evt_commit;
  assign evt_accept = start && (st_q == ST_IDLE);
  assign evt_commit = (st_q == ST_WR);

  bitu_addr_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_BASE(RAM_BASE)) u_map (
    .bit_addr (addr_q),
    .byte_addr(byte_addr),
    .bit_idx  (bit_idx)
  );

  bitu_alu #(.DATA_W(DATA_W)) u_alu (
    .op       (op_q),
    .byte_in  (byte_q),
    .bit_idx  (bit_idx),
    .carry_in (carry_q),
    .wr_need  (alu_wr),
    .byte_out (alu_byte),
    .carry_out(alu_carry),
    .test_hit (alu_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_NONE;
      addr_q  <= '0;
      byte_q  <= '0;
      carry_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (evt_accept) begin
          op_q   <= bitu_op_e'(op);
          addr_q <= bit_addr;
          st_q   <= ST_RD;
        end
        ST_RD: begin
          byte_q <= mem_rd_data;
          st_q   <= ST_WR;
        end
        ST_WR: begin
          carry_q <= alu_carry;
          st_q    <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_rd_addr = byte_addr;
  assign mem_wr_addr = byte_addr;
  assign mem_wr_data = alu_byte;
  assign mem_wr_en   = evt_commit && alu_wr;
  assign jump_take   = evt_commit && alu_hit;
  assign done        = evt_commit;
  assign busy        = (st_q != ST_IDLE);
  assign carry       = carry_q;
endmodule

// File: rtl/bitu_checker.sv
module bitu_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_accept,
  input logic              busy,
  input logic              done,
  input logic              mem_wr_en,
  input logic              jump_take,
  input logic              carry,
  input logic [DATA_W-1:0] mem_rd_data,
  input logic [DATA_W-1:0] mem_wr_data
);
  p_accept_then_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> (busy && !done));
  p_read_then_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> done);
  p_write_in_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> done);
  p_jump_in_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    jump_take |-> done);
  p_one_bit_changed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> ($countones(mem_wr_data ^ mem_rd_data) <= 1));
  p_carry_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(carry));
endmodule

bind bit_boolean_unit bitu_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_accept (evt_accept),
  .busy       (busy),
  .done       (done),
  .mem_wr_en  (mem_wr_en),
  .jump_take  (jump_take),
  .carry      (carry),
  .mem_rd_data(mem_rd_data),
  .mem_wr_data(mem_wr_data)
);

// File: tb/bit_boolean_unit_tb.sv
module bit_boolean_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] op = 4'd15;
  logic [7:0] bit_addr = 8'd0;
  logic [7:0] mem_rd_addr, mem_rd_data, mem_wr_addr, mem_wr_data;
  logic       mem_wr_en, busy, done, jump_take, carry;

  int n_checks = 0;
  int n_errors = 0;

  logic [7:0] mem [256];
  logic [7:0] mdl [256];
  logic       mc = 1'b0;

  typedef struct {
    logic       we;
    logic [7:0] wa;
    logic [7:0] wd;
    logic       jmp;
    logic       c;
    string      req;
  } exp_t;
  exp_t q[$];
  exp_t cur;
  logic carry_due = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bit_boolean_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .bit_addr(bit_addr),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .busy(busy),
    .done(done), .jump_take(jump_take), .carry(carry)
  );

  assign mem_rd_data = mem[mem_rd_addr];
  always @(posedge clk) if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input logic [7:0] a);
    if (a >= 8'h80) return a & 8'hF8;
    return 8'h20 + {4'd0, a[6:3]};
  endfunction

  // monitor: compares commit-cycle outputs, then carry one cycle later
  always @(negedge clk) begin
    if (carry_due) begin
      check(cur.req, "carry", {7'd0, carry}, {7'd0, cur.c});
      carry_due = 1'b0;
    end
    if (rst_n && done) begin
      if (q.size() == 0) begin
        check("R8", "unexpected done", 8'd1, 8'd0);
      end else begin
        cur = q.pop_front();
        check(cur.req, "wr_en", {7'd0, mem_wr_en}, {7'd0, cur.we});
        if (cur.we) begin
          check(cur.req, "wr_addr", mem_wr_addr, cur.wa);
          check(cur.req, "wr_data", mem_wr_data, cur.wd);
        end
        check(cur.req, "jump", {7'd0, jump_take}, {7'd0, cur.jmp});
        carry_due = 1'b1;
      end
    end
  end

  task automatic expect_op(input logic [3:0] o, input logic [7:0] a, input string req);
    exp_t e;
    logic [7:0] ba;
    logic [2:0] bi;
    logic b;
    ba = byte_of(a);
    bi = a[2:0];
    b  = mdl[ba][bi];
    e.we = 1'b0; e.wa = ba; e.wd = mdl[ba]; e.jmp = 1'b0; e.c = mc; e.req = req;
    case (o)
      4'd0:  begin e.we = 1'b1; e.wd[bi] = 1'b1; end
      4'd1:  begin e.we = 1'b1; e.wd[bi] = 1'b0; end
      4'd2:  begin e.we = 1'b1; e.wd[bi] = ~b; end
      4'd3:  e.c = 1'b1;
      4'd4:  e.c = 1'b0;
      4'd5:  e.c = ~mc;
      4'd6:  e.c = mc && b;
      4'd7:  e.c = mc && !b;
      4'd8:  e.c = mc || b;
      4'd9:  e.c = mc || !b;
      4'd10: e.c = b;
      4'd11: begin e.we = 1'b1; e.wd[bi] = mc; end
      4'd12: e.jmp = b;
      4'd13: e.jmp = !b;
      4'd14: begin e.jmp = b; if (b) begin e.we = 1'b1; e.wd[bi] = 1'b0; end end
      default: ;
    endcase
    if (e.we) mdl[ba] = e.wd;
    mc = e.c;
    q.push_back(e);
  endtask

  // driver: called at a negedge with the block idle
  task automatic run_op(input logic [3:0] o, input logic [7:0] a, input string req);
    expect_op(o, a, req);
    start = 1'b1; op = o; bit_addr = a;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 37 + 5);
      mdl[i] = 8'(i * 37 + 5);
    end
    repeat (2) @(negedge clk);
    // R9 reset state
    check("R9", "carry", {7'd0, carry}, 8'd0);
    check("R9", "busy", {7'd0, busy}, 8'd0);
    check("R9", "done", {7'd0, done}, 8'd0);
    check("R9", "wr_en", {7'd0, mem_wr_en}, 8'd0);
    check("R9", "jump", {7'd0, jump_take}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 RAM window and R3 read-modify-write
    run_op(4'd0, 8'h05, "R1");
    run_op(4'd1, 8'h7F, "R1");
    run_op(4'd2, 8'h3A, "R3");
    run_op(4'd2, 8'h3A, "R3");
    run_op(4'd0, 8'h00, "R3");
    // R2 special register space
    run_op(4'd0, 8'h80, "R2");
    run_op(4'd0, 8'h93, "R2");
    run_op(4'd2, 8'hF8, "R2");
    run_op(4'd1, 8'hFF, "R2");
    // R4 carry ops
    run_op(4'd3, 8'h10, "R4");
    run_op(4'd5, 8'h10, "R4");
    run_op(4'd5, 8'h10, "R4");
    run_op(4'd4, 8'h10, "R4");
    // R6 moves
    run_op(4'd0, 8'h21, "R6");
    run_op(4'd10, 8'h21, "R6");
    run_op(4'd11, 8'h4E, "R6");
    run_op(4'd1, 8'h21, "R6");
    run_op(4'd10, 8'h21, "R6");
    run_op(4'd11, 8'h4F, "R6");
    // R5 AND/OR with bit and inverted bit
    run_op(4'd0, 8'h60, "R5");
    run_op(4'd1, 8'h61, "R5");
    for (int cv = 0; cv < 2; cv++) begin
      for (int o = 6; o < 10; o++) begin
        for (int a = 8'h60; a < 8'h62; a++) begin
          run_op(cv[0] ? 4'd3 : 4'd4, 8'h00, "R5");
          run_op(4'(o), 8'(a), "R5");
        end
      end
    end
    // R7 bit tests on set and clear bits
    run_op(4'd12, 8'h60, "R7");
    run_op(4'd12, 8'h61, "R7");
    run_op(4'd13, 8'h60, "R7");
    run_op(4'd13, 8'h61, "R7");
    run_op(4'd14, 8'h60, "R7");
    run_op(4'd14, 8'h60, "R7");
    run_op(4'd14, 8'h61, "R7");
    run_op(4'd12, 8'h60, "R7");
    // R10 no-op
    run_op(4'd3, 8'h00, "R10");
    run_op(4'd15, 8'h60, "R10");
    // R8 start while busy: second request must be ignored
    run_op(4'd1, 8'h55, "R8");
    expect_op(4'd4, 8'h30, "R8");
    start = 1'b1; op = 4'd4; bit_addr = 8'h30;
    @(negedge clk);
    op = 4'd0; bit_addr = 8'h55;
    check("R8", "busy in read cycle", {7'd0, busy}, 8'd1);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check("R8", "idle after two cycles", {7'd0, busy}, 8'd0);
    run_op(4'd12, 8'h55, "R8");
    repeat (3) @(negedge clk);
    check("R8", "queue drained", 8'(q.size()), 8'd0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL R8 watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule